// File: doc/BRIEF.md
# Multi-View Counter-Timer Bank

This block keeps a 64-bit system count that advances by one on every clock cycle. It also presents a second, virtual view of that count: the physical count less a 64-bit offset that software programs. Both views are driven out on every cycle. Beside the counts sit five independent 32-bit down-counting timer channels. Channel 0 is the EL1 physical timer, channel 1 the EL2 physical timer, channel 2 the EL3 physical timer, channel 3 the EL1 virtual timer and channel 4 the EL2 virtual timer. Each channel counts down by one per cycle and wraps modulo 2^32.

When a channel's value steps down to exactly zero, the block does three things: it raises a one-cycle expiry pulse for that channel, it raises a physical interrupt request, and it sets a sticky pending flag. The flag stays set until an acknowledge input clears it. Each channel also reports a fixed interrupt identifier. The value 1023 means that no interrupt is assigned to the channel.

A single write port, made of an enable, a 4-bit address and 64-bit data, loads three kinds of state: the virtual offset, each channel's timer value, and each channel's report-enable control bit. The compare-value view of the timers, the interrupt controller and exception entry all lie outside this block.

Top module: `ctb_timer_bank`

## Requirements
- R1: `phys_cnt` increases by exactly one on every clock edge while not in reset, wrapping modulo 2^64.
- R2: `virt_cnt` always equals `phys_cnt` minus the offset register, modulo 2^64. The offset is loaded from all 64 bits of `wr_data` by a write to address 15 and takes effect on the edge of that write.
- R3: Channel index i (0 to 4) is, in order, EL1 physical, EL2 physical, EL3 physical, EL1 virtual and EL2 virtual. Its timer value is loaded from `wr_data[31:0]` by a write to address i. `expire[i]` and the `chan_id` field at bits [10*i+9:10*i] belong to channel i.
- R4: On every edge with no load, a channel's timer value decrements by one modulo 2^32. A load of K > 0 therefore reaches zero on the K-th following edge. A load of 0 steps to 0xFFFFFFFF and raises no expiry on the next edge.
- R5: A write to a channel's timer value takes priority over that edge's decrement. The loaded value is kept and no expiry is raised for that edge.
- R6: `expire[i]` is high for exactly the one cycle after the edge on which channel i's decremented value became zero, provided its report enable is set. `irq_req` is the OR of all `expire` bits.
- R7: `chan_id` carries the fixed identifiers 13, 10, 1023, 11 and 1023 for channels 0 to 4. `chan_has_irq[i]` is 0 exactly when the identifier is 1023.
- R8: `irq_pending` is set on the edge on which any enabled channel expires. It holds until an edge with `irq_ack` high and no new expiry clears it. An expiry on the same edge as an acknowledge leaves it set.
- R9: A synchronous active-low reset (`rst_n` = 0 at an edge) clears both counts, the offset, all timer values, all expiry pulses and `irq_pending`, and sets every report enable to 1.
- R10: A write to address 8+i sets channel i's report enable from `wr_data[0]`. While it is 0, the channel still counts, but it raises no expiry pulse and does not set `irq_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0-4 timer value, 8-12 control, 15 offset |
| wr_data | input | 64 | Write data |
| irq_ack | input | 1 | Clears the pending flag |
| phys_cnt | output | 64 | Physical system count |
| virt_cnt | output | 64 | Virtual count (physical minus offset) |
| expire | output | 5 | Per-channel one-cycle expiry pulses |
| irq_pending | output | 1 | Sticky interrupt-pending flag |
| irq_req | output | 1 | Physical interrupt request, OR of expiry pulses |
| chan_id | output | 50 | Per-channel 10-bit interrupt identifiers |
| chan_has_irq | output | 5 | Per-channel flag: an identifier other than 1023 is assigned |

## Verification
The assertions check the following on every cycle:
- the one-step advance of the physical count;
- the per-channel decrement, and a load winning over the decrement;
- an expiry pulse appearing only with a zero timer value;
- a disabled channel staying silent;
- the set, hold and clear rules of the pending flag.

Only the bench scenarios can show the following:
- the exact cycle on which a loaded channel fires;
- that a zero load does not fire;
- the channel ordering and the identifier table;
- the virtual view under an offset larger than the count;
- that an acknowledge loses to a simultaneous expiry;
- that a reset in mid-run clears the offset and the pending state.

// File: rtl/ctb_pkg.sv
// Package: shared constants and the per-channel interrupt identifier table
// for the counter-timer bank. Assumes channel order 0..4 as in the brief.
package ctb_pkg;
    localparam int unsigned NO_IRQ_ID = 1023;

    // Return the fixed interrupt identifier of a channel; unknown -> none.
    function automatic int unsigned chan_irq_id(input int unsigned idx);
        case (idx)
            0:       return 13;
            1:       return 10;
            3:       return 11;
            default: return NO_IRQ_ID;
        endcase
    endfunction
endpackage

// File: rtl/ctb_sys_count.sv
// Module: free-running physical count plus an offset-derived virtual view.
// Assumes a synchronous active-low reset; the virtual view is combinational.
module ctb_sys_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off_wr,
    input  logic [CNT_W-1:0] off_data,
    output logic [CNT_W-1:0] phys_cnt,
    output logic [CNT_W-1:0] virt_cnt
);
    logic [CNT_W-1:0] phys_q;
    logic [CNT_W-1:0] off_q;

    // Advance the physical count once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) phys_q <= '0;
        else        phys_q <= phys_q + CNT_W'(1);
    end

    // Hold the programmable virtual offset.
    always_ff @(posedge clk) begin
        if (!rst_n)      off_q <= '0;
        else if (off_wr) off_q <= off_data;
    end

    assign phys_cnt = phys_q;
    assign virt_cnt = phys_q - off_q;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> phys_q == $past(phys_q) + CNT_W'(1));
endmodule

// File: rtl/ctb_timer_chan.sv
// Module: one 32-bit down-counting timer channel with a report enable.
// Assumes a load and the decrement never coexist: the load wins.
module ctb_timer_chan #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ctl_en,
    input  logic [TMR_W-1:0] wr_val,
    input  logic             ctl_val,
    output logic             hit_next,
    output logic             expire
);
    logic [TMR_W-1:0] tval_q;
    logic [TMR_W-1:0] dec;
    logic             en_q;
    logic             expire_q;

    assign dec      = tval_q - TMR_W'(1);
    assign hit_next = !ld_en && en_q && (dec == '0);

    // Load or decrement the timer value.
    always_ff @(posedge clk) begin
        if (!rst_n)     tval_q <= '0;
        else if (ld_en) tval_q <= wr_val;
        else            tval_q <= dec;
    end

    // Hold the report enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b1;
        else if (ctl_en) en_q <= ctl_val;
    end

    // Register the one-cycle expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) expire_q <= 1'b0;
        else        expire_q <= hit_next;
    end

    assign expire = expire_q;

    // R4
    tval_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> tval_q == $past(tval_q) - TMR_W'(1));
    // R5
    tval_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> tval_q == $past(wr_val) && !expire_q);
    // R6
    expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |-> tval_q == '0);
    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !expire_q);
endmodule

// File: rtl/ctb_irq_collect.sv
// Module: sticky pending flag, set by any channel hit, cleared by acknowledge.
// Assumes a set on the same edge as an acknowledge wins.
module ctb_irq_collect #(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_vec,
    input  logic              irq_ack,
    output logic              irq_pending
);
    logic pend_q;

    // Set on any hit, otherwise clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (|hit_vec) | (pend_q & ~irq_ack);
    end

    assign irq_pending = pend_q;

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |=> pend_q);
    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !irq_ack |=> pend_q);
    // R8
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit_vec) && irq_ack |=> !pend_q);
endmodule

// File: rtl/ctb_timer_bank.sv
// Module: top of the counter-timer bank. Decodes the write port, builds the
// system counts, the timer channels, the pending flag and the ID table.
// Assumes NUM_CH <= 7 so that channel and control addresses fit in 4 bits.
module ctb_timer_bank #(
    parameter int CNT_W  = 64,
    parameter int TMR_W  = 32,
    parameter int NUM_CH = 5,
    parameter int ID_W   = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [3:0]             wr_addr,
    input  logic [CNT_W-1:0]       wr_data,
    input  logic                   irq_ack,
    output logic [CNT_W-1:0]       phys_cnt,
    output logic [CNT_W-1:0]       virt_cnt,
    output logic [NUM_CH-1:0]      expire,
    output logic                   irq_pending,
    output logic                   irq_req,
    output logic [NUM_CH*ID_W-1:0] chan_id,
    output logic [NUM_CH-1:0]      chan_has_irq
);
    localparam int ADDR_W   = 4;
    localparam int CTL_BASE = 8;
    localparam int OFF_ADDR = 15;

    logic [NUM_CH-1:0] hit_vec;
    logic              off_wr;

    assign off_wr = wr_en && (wr_addr == ADDR_W'(OFF_ADDR));

    ctb_sys_count #(.CNT_W(CNT_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .off_wr   (off_wr),
        .off_data (wr_data),
        .phys_cnt (phys_cnt),
        .virt_cnt (virt_cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic ld_sel;
        logic ctl_sel;
        logic [ID_W-1:0] id_val;

        assign ld_sel  = wr_en && (wr_addr == ADDR_W'(i));
        assign ctl_sel = wr_en && (wr_addr == ADDR_W'(CTL_BASE + i));

        ctb_timer_chan #(.TMR_W(TMR_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_en    (ld_sel),
            .ctl_en   (ctl_sel),
            .wr_val   (wr_data[TMR_W-1:0]),
            .ctl_val  (wr_data[0]),
            .hit_next (hit_vec[i]),
            .expire   (expire[i])
        );

        assign id_val                  = ID_W'(ctb_pkg::chan_irq_id(i));
        assign chan_id[i*ID_W +: ID_W] = id_val;
        assign chan_has_irq[i]         = (id_val != ID_W'(ctb_pkg::NO_IRQ_ID));
    end

    ctb_irq_collect #(.NUM_CH(NUM_CH)) i_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_vec     (hit_vec),
        .irq_ack     (irq_ack),
        .irq_pending (irq_pending)
    );

    assign irq_req = |expire;
endmodule

// File: tb/test_ctb_timer_bank.sv
`timescale 1ns/1ps
module test_ctb_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        irq_ack = 1'b0;
    logic [63:0] phys_cnt, virt_cnt;
    logic [4:0]  expire, chan_has_irq;
    logic        irq_pending, irq_req;
    logic [49:0] chan_id;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ctb_timer_bank i_ctb_timer_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_ack(irq_ack), .phys_cnt(phys_cnt),
        .virt_cnt(virt_cnt), .expire(expire), .irq_pending(irq_pending),
        .irq_req(irq_req), .chan_id(chan_id), .chan_has_irq(chan_has_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one edge; return 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Perform one register write on the next edge.
    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        chk("R9 phys after reset", phys_cnt, 0);
        chk("R9 virt after reset", virt_cnt, 0);
        chk("R9 pending after reset", irq_pending, 0);
        chk("R9 expire after reset", expire, 0);
    endtask

    task automatic t_count();
        logic [63:0] p0;
        p0 = phys_cnt;
        repeat (7) tick();
        chk("R1 phys step", phys_cnt, p0 + 7);
    endtask

    task automatic t_virtual();
        wr(4'd15, 64'd100);
        chk("R2 virt small offset", virt_cnt, phys_cnt - 64'd100);
        wr(4'd15, 64'hFFFF_FFFF_FFFF_0000);
        chk("R2 virt offset above count", virt_cnt, phys_cnt - 64'hFFFF_FFFF_FFFF_0000);
        tick();
        chk("R2 virt tracks", virt_cnt, phys_cnt + 64'h1_0000);
    endtask

    task automatic t_ids();
        int exp_id [5] = '{13, 10, 1023, 11, 1023};
        for (int i = 0; i < 5; i++) begin
            chk("R7 chan_id", chan_id[i*10 +: 10], exp_id[i]);
            chk("R7 has_irq", chan_has_irq[i], (exp_id[i] != 1023));
        end
    endtask

    task automatic t_expiry();
        wr(4'd0, 64'd3);
        chk("R6 no pulse at load", expire, 0);
        tick();
        tick();
        chk("R4 not yet zero", expire, 0);
        tick();
        chk("R6 ch0 fires at 3rd edge", expire, 5'b00001);
        chk("R6 irq_req", irq_req, 1);
        chk("R8 pending set", irq_pending, 1);
        tick();
        chk("R6 single cycle pulse", expire, 0);
        chk("R8 pending holds", irq_pending, 1);
        do_ack();
        chk("R8 ack clears", irq_pending, 0);
    endtask

    task automatic t_zero_load();
        wr(4'd0, 64'd0);
        tick();
        chk("R4 zero load wraps no fire", expire[0], 0);
        chk("R4 zero load no pending", irq_pending, 0);
    endtask

    task automatic t_priority();
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 64'd1;
        tick();
        tick();
        wr_en = 1'b0;
        chk("R5 write beats decrement", expire[1], 0);
        tick();
        chk("R5 fires after write ends", expire, 5'b00010);
    endtask

    task automatic t_ack_race();
        chk("R8 pending before race", irq_pending, 1);
        wr(4'd4, 64'd2);
        tick();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        chk("R3 ch4 bit position", expire, 5'b10000);
        chk("R8 expiry beats ack", irq_pending, 1);
        do_ack();
        chk("R8 cleared after", irq_pending, 0);
    endtask

    task automatic t_order();
        wr(4'd3, 64'd2);
        tick();
        tick();
        chk("R3 ch3 fires alone", expire, 5'b01000);
        do_ack();
    endtask

    task automatic t_disable();
        wr(4'd10, 64'd0);
        wr(4'd2, 64'd1);
        tick();
        chk("R10 disabled no pulse", expire, 0);
        chk("R10 disabled no pending", irq_pending, 0);
        wr(4'd10, 64'd1);
        wr(4'd2, 64'd1);
        tick();
        chk("R10 re-enabled fires", expire, 5'b00100);
        do_ack();
    endtask

    task automatic t_mid_reset();
        wr(4'd15, 64'd5);
        wr(4'd0, 64'd1);
        tick();
        chk("R9 pending before reset", irq_pending, 1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R9 pending cleared", irq_pending, 0);
        chk("R9 phys cleared", phys_cnt, 0);
        tick();
        chk("R9 offset cleared", virt_cnt, phys_cnt);
    endtask

    initial begin
        t_reset();
        t_count();
        t_virtual();
        t_ids();
        t_expiry();
        t_zero_load();
        t_priority();
        t_ack_race();
        t_order();
        t_disable();
        t_mid_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule